// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Strobe Timer

This block produces the active-low read and write strobes of a parallel ATA channel for programmed I/O and multiword DMA cycles. Every phase of an access is counted in controller clock cycles. The phase lengths are taken from a 32-bit timing word that the block holds. A host request names the access kind: a data transfer or a task-file register access. It also names the direction. Each access runs through a setup phase, an active phase with the strobe low, and a recovery phase with the strobe high. A one-cycle done pulse marks the last recovery cycle. The setup phase is only paid on the first cycle of a burst. A request of the same kind and direction accepted in the done cycle goes straight into the active phase.

The timing word is changed by a masked read-modify-write. The caller supplies a new mode word and a mode class (PIO, multiword DMA or Ultra DMA). Only the bits owned by that class are replaced. Bits 31:28 are carried in the word as enables for the FIFO, PIO bus mastering, DMA and Ultra DMA. They do not alter the strobe timing.

The state machine has four states. IDLE goes to SETUP when a request is accepted. SETUP goes to ACTIVE when the setup count expires. ACTIVE goes to RECOVER when the active count expires. When the recovery count expires, RECOVER goes to one of three states. It goes to ACTIVE on a same-kind request, which is the burst transition. It goes to SETUP on a request of another kind. With no request it goes back to IDLE.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset both strobes are high, done is low, req_ready is high, and cfg_word equals the RESET_WORD parameter (default 0).
- R2: A data access (req_task=0) has three phases, each lasting its field value plus one cycles. Setup uses bits 24:22. The strobe is low for bits 8:4. Recovery uses bits 3:0.
- R3: A task-file access (req_task=1) has the same three phases. Setup uses bits 27:25, active uses bits 17:13 and recovery uses bits 12:9, each lasting its field value plus one cycles.
- R4: req_write=0 drives rd_n low only during the active phase. req_write=1 drives wr_n low only during the active phase. The two strobes are never low together.
- R5: done is high for exactly the last recovery cycle. req_ready is high in IDLE and in that done cycle, and low in every other cycle.
- R6: A request with the same req_task and req_write as the current access, accepted in the done cycle, enters the active phase on the next cycle with no setup phase.
- R7: A request of a different kind or direction accepted in the done cycle starts with a full setup phase.
- R8: A request presented while req_ready is low is ignored and does not change the strobe sequence.
- R9: An update with upd_class=0 (PIO) replaces the cfg_word bits under mask 0xCFC3FFFF and keeps all other bits.
- R10: An update with upd_class=1 (multiword DMA) replaces the bits under mask 0x31C001FF and keeps the rest.
- R11: An update with upd_class=2 (Ultra DMA) replaces the bits under mask 0x303C0000 and keeps the rest.
- R12: An update with upd_class=3 leaves cfg_word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Apply a mode word to the timing word this cycle |
| upd_class | input | 2 | Mode class: 0 PIO, 1 multiword DMA, 2 Ultra DMA, 3 no change |
| upd_word | input | 32 | Mode word; only the class-owned bits are taken |
| cfg_word | output | 32 | Current timing word |
| req_valid | input | 1 | Access request; taken when req_ready is high |
| req_task | input | 1 | 1 = task-file register access, 0 = data transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Block can take a request this cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle pulse in the last recovery cycle |

## Verification
The first reads run on an all-zero timing word, so every phase is one cycle. Later reads run on a word with different values in each field. A mismatch then shows whether the data or the task-file field was chosen, and whether a phase was swapped for another. Reads and writes are run for both access kinds, which separates the two strobes. Back-to-back pairs are issued twice. One pair has the same kind, which tests that setup is skipped. The other pair changes kind, which tests that setup is kept. A request raised during a busy access shows that it is ignored. Mode words with bits set outside their class mask are applied for every class, so any leak through the mask shows on cfg_word and in the timing of the next access.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;

    localparam int CFG_W = 32;
    localparam int PH_W  = 5;

    // field positions inside the timing word
    localparam int DAT_REC_LSB = 0;
    localparam int DAT_REC_W   = 4;
    localparam int DAT_ACT_LSB = 4;
    localparam int DAT_ACT_W   = 5;
    localparam int TF_REC_LSB  = 9;
    localparam int TF_REC_W    = 4;
    localparam int TF_ACT_LSB  = 13;
    localparam int TF_ACT_W    = 5;
    localparam int DAT_SET_LSB = 22;
    localparam int TF_SET_LSB  = 25;
    localparam int SET_W       = 3;

    localparam logic [CFG_W-1:0] MASK_PIO   = 32'hCFC3_FFFF;
    localparam logic [CFG_W-1:0] MASK_MWDMA = 32'h31C0_01FF;
    localparam logic [CFG_W-1:0] MASK_UDMA  = 32'h303C_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER
    } strb_state_e;

    typedef enum logic [1:0] {
        CLS_PIO   = 2'd0,
        CLS_MWDMA = 2'd1,
        CLS_UDMA  = 2'd2,
        CLS_KEEP  = 2'd3
    } mode_cls_e;

    function automatic logic [PH_W-1:0] setup_len(input logic [CFG_W-1:0] w, input logic tf);
        return tf ? PH_W'(w[TF_SET_LSB +: SET_W]) : PH_W'(w[DAT_SET_LSB +: SET_W]);
    endfunction

    function automatic logic [PH_W-1:0] active_len(input logic [CFG_W-1:0] w, input logic tf);
        return tf ? PH_W'(w[TF_ACT_LSB +: TF_ACT_W]) : PH_W'(w[DAT_ACT_LSB +: DAT_ACT_W]);
    endfunction

    function automatic logic [PH_W-1:0] recover_len(input logic [CFG_W-1:0] w, input logic tf);
        return tf ? PH_W'(w[TF_REC_LSB +: TF_REC_W]) : PH_W'(w[DAT_REC_LSB +: DAT_REC_W]);
    endfunction

endpackage

// File: rtl/ata_cfg_merge.sv
module ata_cfg_merge
    import ata_strb_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_WORD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [1:0]       upd_class,
    input  logic [CFG_W-1:0] upd_word,
    output logic [CFG_W-1:0] cfg_word
);

    logic [CFG_W-1:0] cls_mask;

    always_comb begin
        unique case (mode_cls_e'(upd_class))
            CLS_PIO:   cls_mask = MASK_PIO;
            CLS_MWDMA: cls_mask = MASK_MWDMA;
            CLS_UDMA:  cls_mask = MASK_UDMA;
            CLS_KEEP:  cls_mask = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_word <= RESET_WORD;
        else if (upd_valid)
            cfg_word <= (cfg_word & ~cls_mask) | (upd_word & cls_mask);
    end

endmodule

// File: rtl/ata_phase_ctr.sv
module ata_phase_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
    import ata_strb_pkg::*;
#(
    parameter logic [31:0] RESET_WORD = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_valid,
    input  logic [1:0]  upd_class,
    input  logic [31:0] upd_word,
    output logic [31:0] cfg_word,
    input  logic        req_valid,
    input  logic        req_task,
    input  logic        req_write,
    output logic        req_ready,
    output logic        rd_n,
    output logic        wr_n,
    output logic        done
);

    strb_state_e     state, nxt;
    logic            kind_tf, kind_wr;
    logic            ph_load, ph_zero, take;
    logic [PH_W-1:0] ph_val;
    logic            same_kind;

    ata_cfg_merge #(.RESET_WORD(RESET_WORD)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_class (upd_class),
        .upd_word  (upd_word),
        .cfg_word  (cfg_word)
    );

    ata_phase_ctr #(.W(PH_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    assign same_kind = (req_task == kind_tf) && (req_write == kind_wr);

    // next state and phase counter load
    always_comb begin
        nxt     = state;
        ph_load = 1'b0;
        ph_val  = '0;
        take    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt     = ST_SETUP;
                    ph_load = 1'b1;
                    ph_val  = setup_len(cfg_word, req_task);
                    take    = 1'b1;
                end
            end
            ST_SETUP: begin
                if (ph_zero) begin
                    nxt     = ST_ACTIVE;
                    ph_load = 1'b1;
                    ph_val  = active_len(cfg_word, kind_tf);
                end
            end
            ST_ACTIVE: begin
                if (ph_zero) begin
                    nxt     = ST_RECOVER;
                    ph_load = 1'b1;
                    ph_val  = recover_len(cfg_word, kind_tf);
                end
            end
            ST_RECOVER: begin
                if (ph_zero) begin
                    if (req_valid) begin
                        take    = 1'b1;
                        ph_load = 1'b1;
                        if (same_kind) begin
                            nxt    = ST_ACTIVE;
                            ph_val = active_len(cfg_word, req_task);
                        end else begin
                            nxt    = ST_SETUP;
                            ph_val = setup_len(cfg_word, req_task);
                        end
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_tf <= 1'b0;
            kind_wr <= 1'b0;
        end else begin
            state <= nxt;
            if (take) begin
                kind_tf <= req_task;
                kind_wr <= req_write;
            end
        end
    end

    // outputs
    always_comb begin
        rd_n      = !((state == ST_ACTIVE) && !kind_wr);
        wr_n      = !((state == ST_ACTIVE) && kind_wr);
        done      = (state == ST_RECOVER) && ph_zero;
        req_ready = (state == ST_IDLE) || done;
    end

endmodule

// File: rtl/ata_strobe_checker.sv
module ata_strobe_checker
    import ata_strb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        upd_valid,
    input logic [1:0]  upd_class,
    input logic [31:0] cfg_word,
    input logic        req_ready,
    input logic        rd_n,
    input logic        wr_n,
    input logic        done
);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !req_ready);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_strb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && rd_n && wr_n));

    p_udma_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_class == 2'd2) |=>
            ((cfg_word & ~MASK_UDMA) == ($past(cfg_word) & ~MASK_UDMA)));

    p_class_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_class == 2'd3) |=> $stable(cfg_word));

endmodule

bind ata_strobe_timer ata_strobe_checker u_strobe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_class (upd_class),
    .cfg_word  (cfg_word),
    .req_ready (req_ready),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done)
);

// File: tb/ata_strobe_timer_bench.sv
module ata_strobe_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [1:0]  upd_class = 2'd0;
    logic [31:0] upd_word = 32'h0;
    logic [31:0] cfg_word;
    logic        req_valid = 1'b0;
    logic        req_task = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ready, rd_n, wr_n, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_strobe_timer u_ata_strobe_timer (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_class(upd_class), .upd_word(upd_word),
        .cfg_word(cfg_word),
        .req_valid(req_valid), .req_task(req_task), .req_write(req_write),
        .req_ready(req_ready), .rd_n(rd_n), .wr_n(wr_n), .done(done)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // model: queue of expected {rd_n, wr_n, done} per cycle
    logic [2:0]  q[$];
    logic [31:0] mcfg = 32'h0;
    bit          rdy_exp;
    bit          at_done;
    bit          last_tf, last_wr;

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [2:0] e;
        @(negedge clk);
        e       = (q.size() > 0) ? q[0] : 3'b110;
        rdy_exp = (q.size() <= 1);
        at_done = (q.size() == 1);
        check(tag, {59'd0, rd_n, wr_n, done, req_ready, 1'b0}, {59'd0, e, rdy_exp, 1'b0});
        check(tag, {32'd0, cfg_word}, {32'd0, mcfg});
        if (q.size() > 0) void'(q.pop_front());
        req_valid = 1'b0;
        upd_valid = 1'b0;
    endtask

    function automatic int fld(input logic [31:0] w, input int lsb, input int wd);
        return int'((w >> lsb) & ((32'd1 << wd) - 1));
    endfunction

    task automatic drive_req(input bit tf, input bit wr);
        int s, a, r;
        bit burst;
        req_valid = 1'b1;
        req_task  = tf;
        req_write = wr;
        if (rdy_exp) begin
            burst = at_done && (tf == last_tf) && (wr == last_wr);
            s = tf ? fld(mcfg, 25, 3) : fld(mcfg, 22, 3);
            a = tf ? fld(mcfg, 13, 5) : fld(mcfg, 4, 5);
            r = tf ? fld(mcfg, 9, 4)  : fld(mcfg, 0, 4);
            if (!burst)
                for (int i = 0; i <= s; i++) q.push_back(3'b110);
            for (int i = 0; i <= a; i++) q.push_back(wr ? 3'b100 : 3'b010);
            for (int i = 0; i < r; i++) q.push_back(3'b110);
            q.push_back(3'b111);
            last_tf = tf;
            last_wr = wr;
        end
    endtask

    task automatic issue(input bit tf, input bit wr);
        do step(); while (!rdy_exp);
        drive_req(tf, wr);
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    task automatic drive_upd(input logic [1:0] cls, input logic [31:0] w);
        logic [31:0] m;
        case (cls)
            2'd0: m = 32'hCFC3_FFFF;
            2'd1: m = 32'h31C0_01FF;
            2'd2: m = 32'h303C_0000;
            default: m = 32'h0;
        endcase
        upd_valid = 1'b1;
        upd_class = cls;
        upd_word  = w;
        mcfg      = (mcfg & ~m) | (w & m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1 reset strobes/done/ready", {60'd0, rd_n, wr_n, done, req_ready}, {60'd0, 4'b1101});
        check("R1 reset cfg_word", {32'd0, cfg_word}, 64'd0);
        rst_n = 1'b1;
        step();

        tag = "R2 R4 R5 zero-fields";
        issue(1'b0, 1'b0); drain();

        tag = "R9 pio update";
        drive_upd(2'd0, 32'h92BC_6421); step(); step();

        tag = "R2 R4 R5 data read";  issue(1'b0, 1'b0); drain();
        tag = "R2 R4 R5 data write"; issue(1'b0, 1'b1); drain();
        tag = "R3 R4 task read";     issue(1'b1, 1'b0); drain();
        tag = "R3 R4 task write";    issue(1'b1, 1'b1); drain();

        tag = "R6 R5 same-kind burst";
        issue(1'b0, 1'b0); issue(1'b0, 1'b0); issue(1'b0, 1'b0); drain();

        tag = "R7 kind change";
        issue(1'b0, 1'b1); issue(1'b1, 1'b1); issue(1'b1, 1'b0); drain();

        tag = "R8 busy request";
        issue(1'b1, 1'b0);
        step(); step();
        drive_req(1'b0, 1'b1);
        step();
        drive_req(1'b1, 1'b1);
        drain();

        tag = "R10 mwdma update";
        drive_upd(2'd1, 32'h2E40_0042); step(); step();
        issue(1'b0, 1'b0); drain();
        issue(1'b1, 1'b0); drain();

        tag = "R11 udma update";
        drive_upd(2'd2, 32'hFFFF_FFFF); step(); step();
        issue(1'b0, 1'b1); drain();

        tag = "R12 keep class";
        drive_upd(2'd3, 32'h0000_0000); step(); step();
        issue(1'b1, 1'b1); drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule